// File: doc/BRIEF.md
# Chained FIFO Slice Token Controller

This block sits beside the storage of one FIFO slice and decides whether that slice takes part in writes and reads when several slices are chained into one deeper queue. Ownership of the write side and the read side moves around the chain as two tokens. A slice that fills its last location passes the write token to its neighbour. A slice that drains its last location passes the read token in the same way. Each hand-over is an active-low pulse that lasts one clock of the side concerned. The storage and its pointers are outside this block. They appear only as a request input and an "this operation hits the last location" input for each side.

The same three strap inputs have two uses. When the slice is chained, they identify the head of the chain and carry the incoming token pulses. When the slice is used alone or side by side for width, they choose the read timing mode and the almost-flag mode. The write hand-over output then reports the slice's half-full level instead. The strap levels are sampled while reset is held and are kept until the next reset.

Top module: `dchain_ctrl`

## Requirements
- R1: The configuration is taken from the strap pins as they stand at the reset release. If `wxi_n` and `rxi_n` are both high, the slice is chained (`mode_chain`=1), and `fl_n`=0 marks the head (`mode_head`=1). Otherwise the slice is standalone, with `mode_fwft` equal to `fl_n` and `mode_sync_flags` equal to `rxi_n`. Pin changes after the release do not alter the configuration.
- R2: After reset, a chain head holds both the write token and the read token. A chained slice that is not the head holds neither token.
- R3: A standalone slice always holds both tokens. Its `wxi_n` and `rxi_n` levels after reset have no effect on the tokens.
- R4: In a chained slice that holds the write token, a clock edge with `wr_en`=1 and `wr_last`=1 releases the token and drives `wxo_hf_n` low for exactly the following write clock cycle.
- R5: In a chained slice that holds the read token, a clock edge with `rd_en`=1 and `rd_last`=1 releases the token and drives `rxo_n` low for exactly the following read clock cycle.
- R6: In a chained slice, `wxi_n` low at a write clock edge grants the write token, and `rxi_n` low at a read clock edge grants the read token.
- R7: When a token is received at the same edge at which it is released, the slice keeps the token and still emits its outgoing pulse.
- R8: `slice_wr` equals `wr_en` while the write token is held and is 0 otherwise. `slice_rd` equals `rd_en` while the read token is held and is 0 otherwise.
- R9: `q` carries `ram_q` when the read token is held and `oe_n` is low. In every other case `q` is high impedance.
- R10: In a standalone slice, `wxo_hf_n` follows `half_full_n` and `rxo_n` stays high.
- R11: In a chained slice, `half_full_n` is ignored, and `wxo_hf_n` is high except during a hand-over pulse.
- R12: `wr_last` or `rd_last` causes no hand-over unless the matching enable is high and the token is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write side clock |
| rclk | input | 1 | Read side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_n | input | 1 | Strap: chain head when low; timing mode when standalone |
| wxi_n | input | 1 | Incoming write token pulse, or strap level |
| rxi_n | input | 1 | Incoming read token pulse, or strap level |
| wr_en | input | 1 | Write request |
| wr_last | input | 1 | The current write targets the last location |
| half_full_n | input | 1 | Half-full level from the slice, active low |
| rd_en | input | 1 | Read request |
| rd_last | input | 1 | The current read targets the last location |
| oe_n | input | 1 | Output drive enable, active low |
| ram_q | input | W | Read data from the slice storage |
| slice_wr | output | 1 | Write forwarded to this slice |
| slice_rd | output | 1 | Read forwarded to this slice |
| wr_token | output | 1 | Write token held |
| rd_token | output | 1 | Read token held |
| mode_chain | output | 1 | Slice is chained |
| mode_head | output | 1 | Slice is the chain head |
| mode_fwft | output | 1 | Fall-through timing selected |
| mode_sync_flags | output | 1 | Synchronous almost flags selected |
| wxo_hf_n | output | 1 | Outgoing write token pulse, or half-full flag |
| rxo_n | output | 1 | Outgoing read token pulse |
| q | output | W | Read data, high impedance unless selected |

## Verification
The main coincidence is a token arriving at the same edge at which the slice gives the same token away. The receive must win, and the outgoing pulse must still appear. The bench sets this up directly: it drives `wxi_n` low together with a last-location write while the slice holds the token, and it does the same on the read side. Random runs produce further cases when the sparse incoming pulses line up with a last-location operation. At each cycle, a reference model of the token state and pulse outputs judges the token outputs and the pulse lines in the cycle after the edge.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  typedef struct packed {
    logic chained;
    logic head;
    logic fwft;
    logic sync_flags;
  } exp_cfg_t;

  // Strap decode: both expansion inputs idle-high means a chain.
  function automatic exp_cfg_t decode_straps(input logic fl_n,
                                             input logic wxi_n,
                                             input logic rxi_n);
    exp_cfg_t c;
    c.chained    = wxi_n & rxi_n;
    c.head       = wxi_n & rxi_n & ~fl_n;
    c.fwft       = ~(wxi_n & rxi_n) & fl_n;
    c.sync_flags = ~(wxi_n & rxi_n) & rxi_n;
    return c;
  endfunction

  // Token owned out of reset: head of a chain, or any standalone slice.
  function automatic logic initial_token(input exp_cfg_t c);
    return ~c.chained | c.head;
  endfunction

endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar i = 0; i <= LAST; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else begin
          if (i == 0) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/dchain_cfg_cap.sv
module dchain_cfg_cap
  import dchain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     srst_n,
  input  exp_cfg_t live_cfg,
  output exp_cfg_t cfg
);
  exp_cfg_t cfg_q, cfg_d;
  logic     cap_en;

  assign cap_en = ~srst_n;

  always_comb begin
    cfg_d = cfg_q;
    if (cap_en) cfg_d = live_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // Once out of reset the configuration is frozen.
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $past(srst_n) |-> $stable(cfg_q));
endmodule

// File: rtl/dchain_token.sv
module dchain_token (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_n,
  input  logic init_tok,
  input  logic chained,
  input  logic xi_n,
  input  logic op,
  input  logic last,
  output logic tok,
  output logic xo_pulse
);
  logic tok_q, tok_d;
  logic pulse_q, pulse_d;
  logic take, give;

  assign take = chained & ~xi_n;
  assign give = chained & tok_q & op & last;

  always_comb begin
    tok_d   = tok_q;
    pulse_d = 1'b0;
    if (!srst_n) begin
      tok_d = init_tok;
    end else if (!chained) begin
      tok_d = 1'b1;
    end else begin
      pulse_d = give;
      if (take)      tok_d = 1'b1;
      else if (give) tok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tok_q   <= tok_d;
      pulse_q <= pulse_d;
    end
  end

  assign tok      = tok_q;
  assign xo_pulse = pulse_q;

  assert_standalone_owns_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !chained |-> tok_q);
  assert_pulse_from_owner_R4: assert property (@(posedge clk) disable iff (!srst_n)
    pulse_q |-> $past(tok_q));
  assert_receive_grants_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (chained && !xi_n) |=> tok_q);
  assert_release_clears_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (chained && tok_q && op && last && xi_n) |=> !tok_q);
  assert_same_edge_keeps_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (chained && tok_q && op && last && !xi_n) |=> (tok_q && pulse_q));
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
  import dchain_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         fl_n,
  input  logic         wxi_n,
  input  logic         rxi_n,
  input  logic         wr_en,
  input  logic         wr_last,
  input  logic         half_full_n,
  input  logic         rd_en,
  input  logic         rd_last,
  input  logic         oe_n,
  input  logic [W-1:0] ram_q,
  output logic         slice_wr,
  output logic         slice_rd,
  output logic         wr_token,
  output logic         rd_token,
  output logic         mode_chain,
  output logic         mode_head,
  output logic         mode_fwft,
  output logic         mode_sync_flags,
  output logic         wxo_hf_n,
  output logic         rxo_n,
  output logic [W-1:0] q
);
  logic     w_srst_n, r_srst_n;
  exp_cfg_t live_cfg, w_cfg, r_cfg;
  logic     init_tok;
  logic     w_tok, r_tok, w_pulse, r_pulse;
  logic     q_drive;

  assign live_cfg = decode_straps(fl_n, wxi_n, rxi_n);
  assign init_tok = initial_token(live_cfg);

  dchain_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wclk), .rst_n(rst_n), .srst_n(w_srst_n));
  dchain_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk(rclk), .rst_n(rst_n), .srst_n(r_srst_n));

  dchain_cfg_cap u_wcfg (
    .clk(wclk), .rst_n(rst_n), .srst_n(w_srst_n),
    .live_cfg(live_cfg), .cfg(w_cfg));
  dchain_cfg_cap u_rcfg (
    .clk(rclk), .rst_n(rst_n), .srst_n(r_srst_n),
    .live_cfg(live_cfg), .cfg(r_cfg));

  dchain_token u_wtok (
    .clk(wclk), .rst_n(rst_n), .srst_n(w_srst_n), .init_tok(init_tok),
    .chained(w_cfg.chained), .xi_n(wxi_n), .op(wr_en), .last(wr_last),
    .tok(w_tok), .xo_pulse(w_pulse));
  dchain_token u_rtok (
    .clk(rclk), .rst_n(rst_n), .srst_n(r_srst_n), .init_tok(init_tok),
    .chained(r_cfg.chained), .xi_n(rxi_n), .op(rd_en), .last(rd_last),
    .tok(r_tok), .xo_pulse(r_pulse));

  assign wr_token = w_tok;
  assign rd_token = r_tok;
  assign slice_wr = wr_en & w_tok;
  assign slice_rd = rd_en & r_tok;

  assign mode_chain      = w_cfg.chained;
  assign mode_head       = w_cfg.head;
  assign mode_fwft       = w_cfg.fwft;
  assign mode_sync_flags = w_cfg.sync_flags;

  // Shared pin: hand-over pulse when chained, half-full level otherwise.
  assign wxo_hf_n = w_cfg.chained ? ~w_pulse : half_full_n;
  assign rxo_n    = ~(r_cfg.chained & r_pulse);

  assign q_drive = r_tok & ~oe_n;
  assign q       = q_drive ? ram_q : {W{1'bz}};

  assert_wr_gated_R8: assert property (@(posedge wclk) disable iff (!w_srst_n)
    !wr_token |-> !slice_wr);
  assert_rd_gated_R8: assert property (@(posedge rclk) disable iff (!r_srst_n)
    !rd_token |-> !slice_rd);
  assert_rxo_idle_R10: assert property (@(posedge rclk) disable iff (!r_srst_n)
    !r_cfg.chained |-> rxo_n);
  assert_hf_ignored_R11: assert property (@(posedge wclk) disable iff (!w_srst_n)
    (w_cfg.chained && !wr_token && !$past(wr_token)) |-> wxo_hf_n);
endmodule

// File: tb/sim_dchain_ctrl.sv
module sim_dchain_ctrl;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n, fl_n, wxi_n, rxi_n, wr_en, wr_last, half_full_n;
  logic rd_en, rd_last, oe_n;
  logic [W-1:0] ram_q, q;
  logic slice_wr, slice_rd, wr_token, rd_token;
  logic mode_chain, mode_head, mode_fwft, mode_sync_flags, wxo_hf_n, rxo_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit m_chain, m_wt, m_wp, m_rt, m_rp;

  always #10 clk = ~clk;

  dchain_ctrl #(.W(W)) u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fl_n(fl_n), .wxi_n(wxi_n),
    .rxi_n(rxi_n), .wr_en(wr_en), .wr_last(wr_last), .half_full_n(half_full_n),
    .rd_en(rd_en), .rd_last(rd_last), .oe_n(oe_n), .ram_q(ram_q),
    .slice_wr(slice_wr), .slice_rd(slice_rd), .wr_token(wr_token),
    .rd_token(rd_token), .mode_chain(mode_chain), .mode_head(mode_head),
    .mode_fwft(mode_fwft), .mode_sync_flags(mode_sync_flags),
    .wxo_hf_n(wxo_hf_n), .rxo_n(rxo_n), .q(q));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_q(input bit tok, input logic oe, input logic [W-1:0] d);
    return (tok && !oe) ? d : {W{1'bz}};
  endfunction

  task automatic idle();
    wr_en = 0; wr_last = 0; rd_en = 0; rd_last = 0; oe_n = 1;
    half_full_n = 1; ram_q = '0;
  endtask

  task automatic do_reset(input logic f, input logic wx, input logic rx);
    idle();
    fl_n = f; wxi_n = wx; rxi_n = rx;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    m_chain = wx & rx;
    m_wt = !m_chain || !f; m_rt = m_wt; m_wp = 0; m_rp = 0;
    chk("R1 chain", {17'd0, mode_chain}, {17'd0, m_chain});
    chk("R1 head", {17'd0, mode_head}, {17'd0, m_chain & ~f});
    chk("R1 fwft", {17'd0, mode_fwft}, {17'd0, ~m_chain & f});
    chk("R1 sync", {17'd0, mode_sync_flags}, {17'd0, ~m_chain & rx});
    chk("R2 wtok", {17'd0, wr_token}, {17'd0, m_wt});
    chk("R2 rtok", {17'd0, rd_token}, {17'd0, m_rt});
  endtask

  // One clock: model the edge with the inputs that were applied, then compare.
  task automatic step();
    bit wg, wk, rg, rk;
    wg = m_chain && m_wt && wr_en && wr_last;
    wk = m_chain && !wxi_n;
    rg = m_chain && m_rt && rd_en && rd_last;
    rk = m_chain && !rxi_n;
    @(negedge clk);
    m_wt = m_chain ? (wk || (m_wt && !wg)) : 1'b1;
    m_rt = m_chain ? (rk || (m_rt && !rg)) : 1'b1;
    m_wp = wg; m_rp = rg;
    chk("R4/R6/R7 wr_token", {17'd0, wr_token}, {17'd0, m_wt});
    chk("R5/R6/R7 rd_token", {17'd0, rd_token}, {17'd0, m_rt});
    chk("R4/R10/R11 wxo_hf_n", {17'd0, wxo_hf_n},
        {17'd0, m_chain ? ~m_wp : half_full_n});
    chk("R5/R10 rxo_n", {17'd0, rxo_n}, {17'd0, ~(m_chain & m_rp)});
    chk("R8 slice_wr", {17'd0, slice_wr}, {17'd0, wr_en & m_wt});
    chk("R8 slice_rd", {17'd0, slice_rd}, {17'd0, rd_en & m_rt});
    chk("R9 q", q, exp_q(m_rt, oe_n, ram_q));
  endtask

  task automatic rand_inputs(input bit chain, input int pulse_odds);
    wr_en = $urandom_range(0, 1); wr_last = ($urandom_range(0, 3) == 0);
    rd_en = $urandom_range(0, 1); rd_last = ($urandom_range(0, 3) == 0);
    oe_n = ($urandom_range(0, 3) == 0); half_full_n = $urandom_range(0, 1);
    ram_q = W'($urandom);
    if (chain) begin
      wxi_n = ($urandom_range(0, pulse_odds) != 0);
      rxi_n = ($urandom_range(0, pulse_odds) != 0);
    end else begin
      wxi_n = $urandom_range(0, 1);
      rxi_n = $urandom_range(0, 1);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // Chain head: directed hand-overs.
    do_reset(1'b0, 1'b1, 1'b1);
    step();
    wr_en = 0; wr_last = 1; rd_en = 0; rd_last = 1; step();   // R12: no enable
    idle(); wr_en = 1; wr_last = 1; step();                   // R4 release
    wr_en = 0; wr_last = 0; step();                           // R4 pulse ended
    wr_en = 1; wr_last = 1; step();                           // R12: no token
    idle(); wxi_n = 0; step();                                // R6 regain
    wxi_n = 0; wr_en = 1; wr_last = 1; step();                // R7 coincidence
    idle(); wxi_n = 1; rd_en = 1; rd_last = 1; oe_n = 0; ram_q = 18'h2A5A5; step(); // R5
    idle(); rxi_n = 0; rd_en = 1; rd_last = 1; step();        // R7 read side, no token
    rxi_n = 0; rd_en = 1; rd_last = 1; oe_n = 0; ram_q = 18'h11111; step(); // R7
    idle(); rxi_n = 1; half_full_n = 0; step();               // R11
    for (int i = 0; i < 400; i++) begin rand_inputs(1, 5); step(); end
    // Chain follower.
    do_reset(1'b1, 1'b1, 1'b1);
    idle(); oe_n = 0; ram_q = 18'h3C3C3; step();               // R9 no token: z
    for (int i = 0; i < 400; i++) begin rand_inputs(1, 7); step(); end
    // Standalone: fall-through, synchronous flags.
    do_reset(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++) begin rand_inputs(0, 0); step(); end
    chk("R1 frozen fwft", {17'd0, mode_fwft}, 18'd1);
    // Standalone: standard timing, asynchronous flags.
    do_reset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 200; i++) begin rand_inputs(0, 0); step(); end
    chk("R3 chain stays off", {17'd0, mode_chain}, 18'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule